// File: doc/BRIEF.md
# Configurable Shift-Clock Timer

This block generates the shift clock that paces a serial shifter. A single 16-bit compare word is interpreted per operating mode. In baud mode, the low byte is a half-period divider and the high byte is a bit count. In PWM mode, the low byte sets the high-phase length and the high byte sets the low-phase length. In wide-count mode, all 16 bits form one half-period divider. A run begins on an edge of a selectable trigger. The trigger is either an external line or one of four internal sources (a pin, a shifter status flag or another timer's trigger output), and its active level is programmable. The timer's clock level is also driven onto one of eight pins through a configurable output stage with selectable polarity.

The controller is a three-state machine. `S_IDLE` holds the clock low and waits. `S_LOW` and `S_HIGH` are the two clock phases, and each lasts until its down-counter reaches zero.

The transitions are:
- IDLE→LOW: start in baud or wide-count mode.
- IDLE→HIGH: start in PWM mode.
- LOW→HIGH: the phase counter expires.
- HIGH→LOW: the phase counter expires and more bits remain.
- HIGH→IDLE: the last bit completes in baud mode. This transition raises a one-cycle done pulse.
- LOW/HIGH→IDLE: the trigger goes inactive in PWM or wide-count mode.
- any→IDLE: the mode is set to off.

Top module: `shift_clk_timer`

## Requirements
- R1: The timer starts only in a cycle where the effective trigger (after polarity) changes from inactive to active while it is idle. A trigger that is already active when reset is released does not start it.
- R2: `cfg_trg_int`=0 selects `ext_trg`. `cfg_trg_int`=1 selects an internal source by `cfg_trg_sel`={N[1:0], s[1:0]}: s=00 selects `pin_in[2N]`, s=01 selects `shf_flag[N]`, s=10 selects `pin_in[2N+1]`, s=11 selects `tmr_trg[N]`. Unselected sources are ignored.
- R3: `cfg_trg_pol`=1 makes the trigger active low. A rising edge of the raw line then does not start the timer, and a falling edge does.
- R4: In baud mode (`cfg_mode`=01), with L=cmp[7:0] and H=cmp[15:8], the clock starts low in the cycle after the start edge. Each phase lasts L+1 cycles, and exactly H+1 high phases are produced.
- R5: In baud mode, the cycle after the last high phase shows `sclk`=0 and `tmr_done`=1 for exactly one cycle. The timer then stays idle even while the trigger remains active.
- R6: In PWM mode (`cfg_mode`=10), the clock starts high for L+1 cycles, then is low for H+1 cycles, alternating. The cycle after the trigger is sampled inactive shows `sclk`=0 and the timer idle, with no done pulse.
- R7: In wide-count mode (`cfg_mode`=11), each phase lasts cmp+1 cycles using all 16 bits, starting low. The timer runs until the trigger is sampled inactive.
- R8: With `cfg_mode`=00, triggers are ignored, and a running timer drops `sclk` low in the next cycle.
- R9: Pin output stage by `cfg_pin_cfg`: 00 gives oe=0 and od=0; 01 gives oe=P and od=0; 10 gives od=P and oe=0; 11 gives oe=1 and od=P. P is the pin value.
- R10: The pin value P is `sclk` XOR `cfg_pin_pol`. Only the pin indexed by `cfg_pin_sel` is driven; all other bits of `pin_oe` and `pin_od` are 0.
- R11: After synchronous reset, `sclk`=0, `tmr_done`=0 and the timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 2 | 00 off, 01 baud, 10 PWM, 11 wide count |
| cfg_cmp | input | 16 | Compare word |
| cfg_trg_int | input | 1 | 0 external trigger, 1 internal trigger |
| cfg_trg_sel | input | 4 | Internal trigger select {N, s} |
| cfg_trg_pol | input | 1 | Trigger polarity, 1 = active low |
| cfg_pin_cfg | input | 2 | Pin output stage configuration |
| cfg_pin_pol | input | 1 | Pin polarity, 1 = active low |
| cfg_pin_sel | input | 3 | Driven pin index |
| ext_trg | input | 1 | External trigger line |
| pin_in | input | 8 | Pin input levels |
| shf_flag | input | 4 | Shifter status flags |
| tmr_trg | input | 4 | Trigger outputs of other timers |
| sclk | output | 1 | Shift clock |
| tmr_done | output | 1 | One-cycle done / trigger output |
| pin_od | output | 8 | Pin output data |
| pin_oe | output | 8 | Pin output enable |

## Verification
The bench targets off-by-one phase lengths with a zero divider and a single-bit transfer; a wrong reload would stretch or skip a phase, or add or drop a high pulse. It runs wide-count mode with a compare of 256 so that a design truncating to the low byte would toggle every cycle. It holds the trigger active across reset release and after completion, which catches a level-started design that restarts spuriously. It also pulses unselected internal sources and inverts polarity, so a wrong mux index or an edge taken on the wrong sense would start the clock.

// File: rtl/shift_clk_timer_pkg.sv
package shift_clk_timer_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_BAUD = 2'b01,
        MODE_PWM  = 2'b10,
        MODE_WIDE = 2'b11
    } tmr_mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_LOW  = 2'b01,
        S_HIGH = 2'b10
    } tmr_state_e;

    typedef enum logic [1:0] {
        PIN_OFF  = 2'b00,
        PIN_OE   = 2'b01,
        PIN_DATA = 2'b10,
        PIN_OUT  = 2'b11
    } pin_cfg_e;

endpackage

// File: rtl/sct_trigger.sv
module sct_trigger #(
    parameter int NUM_PINS = 8,
    localparam int NGRP   = NUM_PINS / 2,
    localparam int NSEL_W = $clog2(NGRP),
    localparam int TSEL_W = NSEL_W + 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                use_int,
    input  logic [TSEL_W-1:0]   sel,
    input  logic                pol,
    input  logic                ext_trg,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NGRP-1:0]     shf_flag,
    input  logic [NGRP-1:0]     tmr_trg,
    output logic                trg_act,
    output logic                trg_rise
);
    logic [NSEL_W-1:0] grp;
    logic              int_raw;
    logic              raw;
    logic              act_q;

    assign grp = sel[TSEL_W-1:2];

    always_comb begin
        unique case (sel[1:0])
            2'b00: int_raw = pin_in[{grp, 1'b0}];
            2'b01: int_raw = shf_flag[grp];
            2'b10: int_raw = pin_in[{grp, 1'b1}];
            2'b11: int_raw = tmr_trg[grp];
        endcase
    end

    assign raw      = use_int ? int_raw : ext_trg;
    assign trg_act  = raw ^ pol;
    assign trg_rise = trg_act & ~act_q;

    // held high in reset so a trigger already active on release is not an edge
    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b1;
        else     act_q <= trg_act;
    end
endmodule

// File: rtl/sct_pin_drive.sv
module sct_pin_drive
    import shift_clk_timer_pkg::*;
#(
    parameter int NUM_PINS = 8,
    localparam int PSEL_W = $clog2(NUM_PINS)
) (
    input  logic                level,
    input  logic [1:0]          cfg,
    input  logic                pol,
    input  logic [PSEL_W-1:0]   sel,
    output logic [NUM_PINS-1:0] pin_od,
    output logic [NUM_PINS-1:0] pin_oe
);
    logic pv;
    logic drv_od;
    logic drv_oe;

    assign pv = level ^ pol;

    always_comb begin
        unique case (pin_cfg_e'(cfg))
            PIN_OFF:  begin drv_oe = 1'b0; drv_od = 1'b0; end
            PIN_OE:   begin drv_oe = pv;   drv_od = 1'b0; end
            PIN_DATA: begin drv_oe = 1'b0; drv_od = pv;   end
            PIN_OUT:  begin drv_oe = 1'b1; drv_od = pv;   end
        endcase
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam logic [PSEL_W-1:0] IDX = PSEL_W'(i);
        assign pin_od[i] = (sel == IDX) & drv_od;
        assign pin_oe[i] = (sel == IDX) & drv_oe;
    end
endmodule

// File: rtl/shift_clk_timer.sv
module shift_clk_timer
    import shift_clk_timer_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int CMP_W    = 16,
    localparam int HALF   = CMP_W / 2,
    localparam int NGRP   = NUM_PINS / 2,
    localparam int TSEL_W = $clog2(NGRP) + 2,
    localparam int PSEL_W = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          cfg_mode,
    input  logic [CMP_W-1:0]    cfg_cmp,
    input  logic                cfg_trg_int,
    input  logic [TSEL_W-1:0]   cfg_trg_sel,
    input  logic                cfg_trg_pol,
    input  logic [1:0]          cfg_pin_cfg,
    input  logic                cfg_pin_pol,
    input  logic [PSEL_W-1:0]   cfg_pin_sel,
    input  logic                ext_trg,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NGRP-1:0]     shf_flag,
    input  logic [NGRP-1:0]     tmr_trg,
    output logic                sclk,
    output logic                tmr_done,
    output logic [NUM_PINS-1:0] pin_od,
    output logic [NUM_PINS-1:0] pin_oe
);
    tmr_mode_e  mode;
    tmr_state_e state, nxt;
    logic [CMP_W-1:0] cnt, cnt_n;
    logic [HALF-1:0]  bits, bits_n;
    logic             done_q, done_n;
    logic             trg_act, trg_rise;
    logic [CMP_W-1:0] lo_byte, hi_byte, reload_hi, reload_lo;

    assign mode    = tmr_mode_e'(cfg_mode);
    assign lo_byte = {{HALF{1'b0}}, cfg_cmp[HALF-1:0]};
    assign hi_byte = {{HALF{1'b0}}, cfg_cmp[CMP_W-1:HALF]};

    sct_trigger #(.NUM_PINS(NUM_PINS)) u_trg (
        .clk      (clk),
        .rst      (rst),
        .use_int  (cfg_trg_int),
        .sel      (cfg_trg_sel),
        .pol      (cfg_trg_pol),
        .ext_trg  (ext_trg),
        .pin_in   (pin_in),
        .shf_flag (shf_flag),
        .tmr_trg  (tmr_trg),
        .trg_act  (trg_act),
        .trg_rise (trg_rise)
    );

    // reload values per phase, chosen by mode
    always_comb begin
        unique case (mode)
            MODE_PWM:  begin reload_hi = lo_byte; reload_lo = hi_byte; end
            MODE_WIDE: begin reload_hi = cfg_cmp; reload_lo = cfg_cmp; end
            default:   begin reload_hi = lo_byte; reload_lo = lo_byte; end
        endcase
    end

    // next-state logic
    always_comb begin
        nxt    = state;
        cnt_n  = cnt;
        bits_n = bits;
        done_n = 1'b0;
        if (mode == MODE_OFF) begin
            nxt = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (trg_rise) begin
                        bits_n = cfg_cmp[CMP_W-1:HALF];
                        if (mode == MODE_PWM) begin
                            nxt   = S_HIGH;
                            cnt_n = lo_byte;
                        end else begin
                            nxt   = S_LOW;
                            cnt_n = (mode == MODE_WIDE) ? cfg_cmp : lo_byte;
                        end
                    end
                end
                S_LOW, S_HIGH: begin
                    if (mode != MODE_BAUD && !trg_act) begin
                        nxt = S_IDLE;
                    end else if (cnt != '0) begin
                        cnt_n = cnt - 1'b1;
                    end else if (state == S_LOW) begin
                        nxt   = S_HIGH;
                        cnt_n = reload_hi;
                    end else if (mode == MODE_BAUD && bits == '0) begin
                        nxt    = S_IDLE;
                        done_n = 1'b1;
                    end else begin
                        if (mode == MODE_BAUD) bits_n = bits - 1'b1;
                        nxt   = S_LOW;
                        cnt_n = reload_lo;
                    end
                end
                default: nxt = S_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            cnt    <= '0;
            bits   <= '0;
            done_q <= 1'b0;
        end else begin
            state  <= nxt;
            cnt    <= cnt_n;
            bits   <= bits_n;
            done_q <= done_n;
        end
    end

    // outputs
    always_comb begin
        sclk     = (state == S_HIGH);
        tmr_done = done_q;
    end

    sct_pin_drive #(.NUM_PINS(NUM_PINS)) u_pin (
        .level  (sclk),
        .cfg    (cfg_pin_cfg),
        .pol    (cfg_pin_pol),
        .sel    (cfg_pin_sel),
        .pin_od (pin_od),
        .pin_oe (pin_oe)
    );

    assert_idle_waits_edge_R1: assert property (@(posedge clk) disable iff (rst)
        (state == S_IDLE && !trg_rise) |=> (state == S_IDLE));

    assert_done_after_high_R5: assert property (@(posedge clk) disable iff (rst)
        tmr_done |-> $past(sclk));

    assert_done_single_R5: assert property (@(posedge clk) disable iff (rst)
        tmr_done |=> !tmr_done);

    assert_off_drops_clock_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_mode == 2'b00) |=> !sclk);

    assert_one_pin_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(pin_oe) && $onehot0(pin_od));
endmodule

// File: tb/tb_shift_clk_timer.sv
`timescale 1ns/1ps
module tb_shift_clk_timer;
    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] cfg_mode;
    logic [15:0] cfg_cmp;
    logic       cfg_trg_int;
    logic [3:0] cfg_trg_sel;
    logic       cfg_trg_pol;
    logic [1:0] cfg_pin_cfg;
    logic       cfg_pin_pol;
    logic [2:0] cfg_pin_sel;
    logic       ext_trg;
    logic [7:0] pin_in;
    logic [3:0] shf_flag;
    logic [3:0] tmr_trg;
    logic       sclk, tmr_done;
    logic [7:0] pin_od, pin_oe;

    int n_chk = 0;
    int n_fail = 0;
    logic [1:0] q_exp[$];
    string      q_req[$];

    always #4 clk = ~clk;

    shift_clk_timer dut (
        .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_cmp(cfg_cmp),
        .cfg_trg_int(cfg_trg_int), .cfg_trg_sel(cfg_trg_sel), .cfg_trg_pol(cfg_trg_pol),
        .cfg_pin_cfg(cfg_pin_cfg), .cfg_pin_pol(cfg_pin_pol), .cfg_pin_sel(cfg_pin_sel),
        .ext_trg(ext_trg), .pin_in(pin_in), .shf_flag(shf_flag), .tmr_trg(tmr_trg),
        .sclk(sclk), .tmr_done(tmr_done), .pin_od(pin_od), .pin_oe(pin_oe)
    );

    // push n expected {sclk, done} samples
    task automatic push(input logic s, input logic d, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            q_exp.push_back({s, d});
            q_req.push_back(req);
        end
    endtask

    task automatic drain();
        while (q_exp.size() != 0) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // monitor: compares each produced cycle against the scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_exp.size() != 0) begin
                logic [1:0] e;
                string r;
                e = q_exp.pop_front();
                r = q_req.pop_front();
                check(r, {14'd0, sclk, tmr_done}, {14'd0, e});
            end
        end
    end

    task automatic baud_seq(input int l, input int h, input string req);
        for (int b = 0; b <= h; b++) begin
            push(1'b0, 1'b0, l + 1, req);
            push(1'b1, 1'b0, l + 1, req);
        end
        push(1'b0, 1'b1, 1, "R5");
        push(1'b0, 1'b0, 1, "R5");
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_mode = 2'b00; cfg_cmp = 16'h0; cfg_trg_int = 1'b0;
        cfg_trg_sel = 4'h0; cfg_trg_pol = 1'b0; cfg_pin_cfg = 2'b11; cfg_pin_pol = 1'b0;
        cfg_pin_sel = 3'd5; ext_trg = 1'b0; pin_in = 8'h0; shf_flag = 4'h0; tmr_trg = 4'h0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state, R9 plain output with sclk low
        check("R11", {14'd0, sclk, tmr_done}, 16'h0);
        check("R9", {pin_oe, pin_od}, {8'h20, 8'h00});

        // R4 R5: baud L=2 H=1, then trigger held: no restart
        cfg_mode = 2'b01; cfg_cmp = 16'h0102;
        @(negedge clk);
        baud_seq(2, 1, "R4");
        push(1'b0, 1'b0, 5, "R5");
        ext_trg = 1'b1;
        drain();
        ext_trg = 1'b0;
        @(negedge clk);

        // R4 boundary: L=0 H=0
        cfg_cmp = 16'h0000;
        baud_seq(0, 0, "R4");
        ext_trg = 1'b1;
        drain();
        ext_trg = 1'b0;
        @(negedge clk);

        // R6: PWM high 2 cycles, low 3 cycles, stop on trigger drop
        cfg_mode = 2'b10; cfg_cmp = 16'h0201;
        for (int p = 0; p < 2; p++) begin
            push(1'b1, 1'b0, 2, "R6");
            push(1'b0, 1'b0, 3, "R6");
        end
        ext_trg = 1'b1;
        repeat (10) @(negedge clk);
        ext_trg = 1'b0;
        push(1'b0, 1'b0, 3, "R6");
        drain();

        // R7: wide count, 257-cycle phases (upper byte matters)
        cfg_mode = 2'b11; cfg_cmp = 16'h0100;
        push(1'b0, 1'b0, 257, "R7");
        push(1'b1, 1'b0, 257, "R7");
        ext_trg = 1'b1;
        repeat (514) @(negedge clk);
        ext_trg = 1'b0;
        push(1'b0, 1'b0, 2, "R7");
        drain();

        // R1: trigger already active at reset release
        cfg_mode = 2'b01; cfg_cmp = 16'h0000;
        rst = 1'b1; ext_trg = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        push(1'b0, 1'b0, 4, "R1");
        drain();
        ext_trg = 1'b0;
        @(negedge clk);

        // R2: internal select {N=2, s=10} -> pin_in[5]; others ignored
        cfg_mode = 2'b00; cfg_trg_int = 1'b1; cfg_trg_sel = 4'b1010;
        @(negedge clk);
        cfg_mode = 2'b01;
        @(negedge clk);
        pin_in[4] = 1'b1; shf_flag[2] = 1'b1; tmr_trg[2] = 1'b1; ext_trg = 1'b1;
        push(1'b0, 1'b0, 4, "R2");
        drain();
        baud_seq(0, 0, "R2");
        pin_in[5] = 1'b1;
        drain();
        // {N=1, s=11} -> tmr_trg[1]
        cfg_trg_sel = 4'b0111;
        @(negedge clk);
        baud_seq(0, 0, "R2");
        tmr_trg[1] = 1'b1;
        drain();
        // {N=3, s=01} -> shf_flag[3]
        cfg_trg_sel = 4'b1101;
        @(negedge clk);
        baud_seq(0, 0, "R2");
        shf_flag[3] = 1'b1;
        drain();
        pin_in = 8'h0; shf_flag = 4'h0; tmr_trg = 4'h0; ext_trg = 1'b0;
        cfg_trg_int = 1'b0;

        // R3: active-low; raw rise ignored, raw fall starts
        cfg_mode = 2'b00; cfg_trg_pol = 1'b1; ext_trg = 1'b1;
        repeat (2) @(negedge clk);
        cfg_mode = 2'b01;
        ext_trg = 1'b0;
        baud_seq(0, 0, "R3");
        drain();
        push(1'b0, 1'b0, 3, "R3");
        ext_trg = 1'b1;
        drain();
        cfg_mode = 2'b00; cfg_trg_pol = 1'b0; ext_trg = 1'b0;
        @(negedge clk);

        // R8: trigger ignored while off
        push(1'b0, 1'b0, 4, "R8");
        ext_trg = 1'b1;
        drain();
        ext_trg = 1'b0;
        // R8 stop mid-run, R9 R10 pin during high phase
        cfg_mode = 2'b10; cfg_cmp = 16'h0505; cfg_pin_sel = 3'd2;
        @(negedge clk);
        push(1'b1, 1'b0, 3, "R8");
        ext_trg = 1'b1;
        drain();
        check("R10", {pin_oe, pin_od}, {8'h04, 8'h04});
        cfg_pin_cfg = 2'b10; cfg_pin_pol = 1'b1;
        #1 check("R10", {pin_oe, pin_od}, {8'h00, 8'h00});
        cfg_pin_pol = 1'b0;
        #1 check("R9", {pin_oe, pin_od}, {8'h00, 8'h04});
        cfg_mode = 2'b00;
        push(1'b0, 1'b0, 2, "R8");
        drain();
        ext_trg = 1'b0;

        // R9 R10 in idle (sclk=0) with active-low pin
        cfg_pin_pol = 1'b1; cfg_pin_sel = 3'd3;
        cfg_pin_cfg = 2'b01;
        #1 check("R9", {pin_oe, pin_od}, {8'h08, 8'h00});
        cfg_pin_cfg = 2'b10;
        #1 check("R9", {pin_oe, pin_od}, {8'h00, 8'h08});
        cfg_pin_cfg = 2'b00;
        #1 check("R9", {pin_oe, pin_od}, {8'h00, 8'h00});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule